// File: doc/BRIEF.md
# Bloom-Bloomier Membership Query Unit

This unit screens fixed-length byte windows taken from a scanned stream against a preloaded set of patterns. For every window the caller supplies four precomputed table indices and a window tag. Each index selects one entry of an index table. An entry carries a single presence bit and a 12-bit code slice. The presence bits across all entries form a plain Bloom filter. If any of the four addressed presence bits is clear, the window is rejected straight away. When all four are set, the four code slices are XOR-combined into the address of the one stored pattern that the window may equal. The address and the tag then go to an exact-compare stage outside this block.

The tables are held in two banks of 1024 entries each. Hashes 0 and 1 read bank 0, and hashes 2 and 3 read bank 1, so each bank sees at most two lookups in a cycle. A new window is accepted every cycle, and its result appears exactly two cycles later. Software rebuilds the whole set offline and rewrites the tables entry by entry through a write port. While that port is active, queries are refused.

Top module: `bbf_query_unit`

## Requirements
- R1: After reset every entry of both banks is zero. resValid, resCand and resAddr read 0, and a query issued before any load is not a candidate.
- R2: A query accepted in cycle c (qValid=1, wrEn=0) yields resValid=1 with resTag equal to its qTag in cycle c+2. Idle cycles yield resValid=0.
- R3: resCand is 1 only when all four presence bits are 1. Hash j occupies qHash[10*j+9:10*j] and reads bank j>>1.
- R4: If any of the four addressed presence bits is 0, resCand is 0 and resAddr is 0.
- R5: On a candidate, resAddr equals the XOR of the four code slices read at the hashed positions.
- R6: A cycle with wrEn=1 stores wrBloom as the presence bit and wrSlice as the code slice at entry wrIdx of bank wrBank (0 or 1). Later queries see the new value.
- R7: A query presented in a cycle with wrEn=1 is dropped. No result appears two cycles later.
- R8: Two hashes of one pair may name the same entry. That entry is then read on both ports, and its slice cancels out of the XOR.
- R9: Back-to-back queries, one per cycle, are resolved independently in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| qValid | input | 1 | A query window is presented |
| qTag | input | 8 | Identity of the scanned window |
| qHash | input | 40 | Four 10-bit table indices; hash j in bits [10j+9:10j] |
| wrEn | input | 1 | Table write strobe; blocks queries |
| wrBank | input | 1 | Bank selected for the write |
| wrIdx | input | 10 | Entry written |
| wrBloom | input | 1 | Presence bit to store |
| wrSlice | input | 12 | Code slice to store |
| resValid | output | 1 | Result of a query issued two cycles earlier |
| resCand | output | 1 | Every presence bit hit |
| resAddr | output | 12 | Decoded pattern address, zero when no candidate |
| resTag | output | 8 | Tag of the query that produced this result |

## Verification
Two activities can fall in the same cycle: a table write and a query. During the table load the bench raises qValid together with wrEn on a random quarter of the write cycles. Two cycles later it requires resValid to stay low. A query placed right after a write to an entry it reads must return the freshly written value. A second collision is the two hashes of one bank naming the same entry in one cycle. A directed query does this, and its address must be the XOR without the duplicated slice.

// File: rtl/bbf_pkg.sv
package bbf_pkg;
  typedef struct packed {
    logic lookup;   // read the banks for an accepted window
    logic decode;   // stage-1 data belongs to a live query
    logic load;     // table write in progress
  } bbfStrobe_t;
endpackage

// File: rtl/bbf_bank.sv
module bbf_bank #(
  parameter int IDX_W   = 10,
  parameter int SLICE_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [SLICE_W:0]     wrData,
  input  logic                 rdEn,
  input  logic [IDX_W-1:0]     rdIdxA,
  input  logic [IDX_W-1:0]     rdIdxB,
  output logic [SLICE_W:0]     rdDataA,
  output logic [SLICE_W:0]     rdDataB
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = SLICE_W + 1;

  logic [ENT_W-1:0] mem [DEPTH];

  // Port A carries the write; queries never overlap a write.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wrEn) begin
      mem[wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdDataA <= '0;
      rdDataB <= '0;
    end else if (rdEn) begin
      rdDataA <= mem[rdIdxA];
      rdDataB <= mem[rdIdxB];
    end
  end

  // R7
  no_rd_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && rdEn))
    else $error("bank read and write in the same cycle");
endmodule

// File: rtl/bbf_ctrl.sv
module bbf_ctrl
  import bbf_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             qValid,
  input  logic [TAG_W-1:0] qTag,
  input  logic             wrEn,
  output bbfStrobe_t       strobe,
  output logic             resValid,
  output logic [TAG_W-1:0] resTag
);
  logic             accept;
  logic             stg1Valid;
  logic [TAG_W-1:0] stg1Tag;

  assign accept = qValid & ~wrEn;

  always_comb begin
    strobe.lookup = accept;
    strobe.decode = stg1Valid;
    strobe.load   = wrEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stg1Valid <= 1'b0;
      stg1Tag   <= '0;
      resValid  <= 1'b0;
      resTag    <= '0;
    end else begin
      stg1Valid <= accept;
      stg1Tag   <= qTag;
      resValid  <= stg1Valid;
      resTag    <= stg1Tag;
    end
  end

  // R2
  res_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(qValid && !wrEn, 2))
    else $error("result without an accepted query two cycles earlier");

  // R7
  wr_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn, 2) |-> !resValid)
    else $error("query during write produced a result");
endmodule

// File: rtl/bbf_datapath.sv
module bbf_datapath
  import bbf_pkg::*;
#(
  parameter int NUM_HASH = 4,
  parameter int IDX_W    = 10,
  parameter int SLICE_W  = 12,
  parameter int BANK_W   = 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bbfStrobe_t                strobe,
  input  logic [NUM_HASH*IDX_W-1:0] qHash,
  input  logic [BANK_W-1:0]         wrBank,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic                      wrBloom,
  input  logic [SLICE_W-1:0]        wrSlice,
  output logic                      resCand,
  output logic [SLICE_W-1:0]        resAddr
);
  localparam int NUM_BANKS = NUM_HASH / 2;
  localparam int ENT_W     = SLICE_W + 1;

  logic [ENT_W-1:0]   rdEnt [NUM_HASH];
  logic [ENT_W-1:0]   wrData;
  logic               allBloom;
  logic [SLICE_W-1:0] xorAcc;
  logic               hit;

  assign wrData = {wrBloom, wrSlice};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bankWe;
    assign bankWe = strobe.load && (wrBank == BANK_W'(b));
    bbf_bank #(.IDX_W(IDX_W), .SLICE_W(SLICE_W)) u_bank (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (bankWe),
      .wrIdx   (wrIdx),
      .wrData  (wrData),
      .rdEn    (strobe.lookup),
      .rdIdxA  (qHash[(2*b)*IDX_W +: IDX_W]),
      .rdIdxB  (qHash[(2*b+1)*IDX_W +: IDX_W]),
      .rdDataA (rdEnt[2*b]),
      .rdDataB (rdEnt[2*b+1])
    );
  end

  always_comb begin
    allBloom = 1'b1;
    xorAcc   = '0;
    for (int i = 0; i < NUM_HASH; i++) begin
      allBloom = allBloom & rdEnt[i][SLICE_W];
      xorAcc   = xorAcc ^ rdEnt[i][SLICE_W-1:0];
    end
  end

  assign hit = strobe.decode & allBloom;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resCand <= 1'b0;
      resAddr <= '0;
    end else begin
      resCand <= hit;
      resAddr <= hit ? xorAcc : '0;
    end
  end

  // R4
  no_cand_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resCand |-> (resAddr == '0))
    else $error("address driven without a candidate");

  // R3
  cand_needs_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    resCand |-> $past(strobe.decode))
    else $error("candidate without a live query");
endmodule

// File: rtl/bbf_query_unit.sv
module bbf_query_unit
  import bbf_pkg::*;
#(
  parameter int NUM_HASH = 4,
  parameter int IDX_W    = 10,
  parameter int SLICE_W  = 12,
  parameter int TAG_W    = 8,
  localparam int NUM_BANKS = NUM_HASH / 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      qValid,
  input  logic [TAG_W-1:0]          qTag,
  input  logic [NUM_HASH*IDX_W-1:0] qHash,
  input  logic                      wrEn,
  input  logic [BANK_W-1:0]         wrBank,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic                      wrBloom,
  input  logic [SLICE_W-1:0]        wrSlice,
  output logic                      resValid,
  output logic                      resCand,
  output logic [SLICE_W-1:0]        resAddr,
  output logic [TAG_W-1:0]          resTag
);
  bbfStrobe_t strobe;

  bbf_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .qValid   (qValid),
    .qTag     (qTag),
    .wrEn     (wrEn),
    .strobe   (strobe),
    .resValid (resValid),
    .resTag   (resTag)
  );

  bbf_datapath #(
    .NUM_HASH (NUM_HASH),
    .IDX_W    (IDX_W),
    .SLICE_W  (SLICE_W),
    .BANK_W   (BANK_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .qHash   (qHash),
    .wrBank  (wrBank),
    .wrIdx   (wrIdx),
    .wrBloom (wrBloom),
    .wrSlice (wrSlice),
    .resCand (resCand),
    .resAddr (resAddr)
  );

  // R2
  cand_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    resCand |-> resValid)
    else $error("candidate flag outside a result cycle");
endmodule

// File: tb/tb_bbf_query_unit.sv
module tb_bbf_query_unit;
  logic        clk = 1'b0;
  logic        rstN;
  logic        qValid;
  logic [7:0]  qTag;
  logic [39:0] qHash;
  logic        wrEn;
  logic [0:0]  wrBank;
  logic [9:0]  wrIdx;
  logic        wrBloom;
  logic [11:0] wrSlice;
  logic        resValid;
  logic        resCand;
  logic [11:0] resAddr;
  logic [7:0]  resTag;

  bbf_query_unit dut (
    .clk(clk), .rstN(rstN), .qValid(qValid), .qTag(qTag), .qHash(qHash),
    .wrEn(wrEn), .wrBank(wrBank), .wrIdx(wrIdx), .wrBloom(wrBloom),
    .wrSlice(wrSlice), .resValid(resValid), .resCand(resCand),
    .resAddr(resAddr), .resTag(resTag)
  );

  always #10 clk = ~clk;

  int unsigned chkCnt = 0;
  int unsigned failCnt = 0;

  logic        mBloom [2][1024];
  logic [11:0] mSlice [2][1024];

  logic        e1V, e1C, e2V, e2C;
  logic [11:0] e1A, e2A;
  logic [7:0]  e1T, e2T;
  string       e1R, e2R;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    chkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic expCand(input logic [39:0] h);
    logic c = 1'b1;
    for (int j = 0; j < 4; j++) c &= mBloom[j >> 1][h[10*j +: 10]];
    return c;
  endfunction

  function automatic logic [11:0] expAddr(input logic [39:0] h);
    logic [11:0] a = '0;
    for (int j = 0; j < 4; j++) a ^= mSlice[j >> 1][h[10*j +: 10]];
    return a;
  endfunction

  function automatic logic [39:0] packH(input int h0, input int h1,
                                        input int h2, input int h3);
    return {10'(h3), 10'(h2), 10'(h1), 10'(h0)};
  endfunction

  // One cycle: check the result of the query issued two steps ago, then drive.
  task automatic step(input logic v, input logic [7:0] tg, input logic [39:0] h,
                      input logic w, input logic wb, input logic [9:0] wi,
                      input logic wbl, input logic [11:0] ws, input string req);
    @(negedge clk);
    chk(resValid == e2V, e2R, "resValid", int'(resValid), int'(e2V));
    if (e2V) begin
      chk(resCand == e2C, e2R, "resCand", int'(resCand), int'(e2C));
      chk(resAddr == e2A, e2R, "resAddr", int'(resAddr), int'(e2A));
      chk(resTag == e2T, "R2", "resTag", int'(resTag), int'(e2T));
    end else begin
      chk(resCand == 1'b0, e2R, "resCand idle", int'(resCand), 0);
    end
    e2V = e1V; e2C = e1C; e2A = e1A; e2T = e1T; e2R = e1R;
    if (w) begin
      mBloom[wb][wi] = wbl;
      mSlice[wb][wi] = ws;
    end
    e1V = v && !w;
    e1C = e1V && expCand(h);
    e1A = e1C ? expAddr(h) : 12'h0;
    e1T = tg;
    e1R = req;
    qValid = v; qTag = tg; qHash = h;
    wrEn = w; wrBank = wb; wrIdx = wi; wrBloom = wbl; wrSlice = ws;
  endtask

  task automatic idle(input string req);
    step(1'b0, 8'h0, 40'h0, 1'b0, 1'b0, 10'h0, 1'b0, 12'h0, req);
  endtask

  task automatic wr(input logic b, input int idx, input logic bl,
                    input logic [11:0] s, input string req);
    step(1'b0, 8'h0, 40'h0, 1'b1, b, 10'(idx), bl, s, req);
  endtask

  task automatic qry(input logic [7:0] tg, input logic [39:0] h, input string req);
    step(1'b1, tg, h, 1'b0, 1'b0, 10'h0, 1'b0, 12'h0, req);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'hB10F_0042);
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 1024; i++) begin
        mBloom[b][i] = 1'b0;
        mSlice[b][i] = 12'h0;
      end
    e1V = 0; e1C = 0; e1A = 0; e1T = 0; e1R = "R1";
    e2V = 0; e2C = 0; e2A = 0; e2T = 0; e2R = "R1";
    rstN = 1'b0; qValid = 0; qTag = 0; qHash = 0;
    wrEn = 0; wrBank = 0; wrIdx = 0; wrBloom = 0; wrSlice = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state of the outputs
    chk(resValid == 1'b0, "R1", "resValid reset", int'(resValid), 0);
    chk(resCand == 1'b0, "R1", "resCand reset", int'(resCand), 0);
    chk(resAddr == 12'h0, "R1", "resAddr reset", int'(resAddr), 0);

    // R1 cleared tables: no candidate before any load
    qry(8'h11, packH(1, 2, 3, 4), "R1");
    qry(8'h12, packH(1023, 0, 512, 7), "R1");
    idle("R1"); idle("R1");

    // R6 load all entries, R7 with queries colliding with writes
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 1024; i++) begin
        logic colide;
        colide = ($urandom % 4) == 0;
        step(colide, 8'($urandom), 40'({$urandom, $urandom}), 1'b1, 1'(b),
             10'(i), 1'(($urandom % 8) != 0), 12'($urandom), "R7");
      end
    idle("R7"); idle("R7");

    // R5 directed candidate
    wr(1'b0, 5, 1'b1, 12'hA5C, "R6");
    wr(1'b0, 6, 1'b1, 12'h3F0, "R6");
    wr(1'b1, 7, 1'b1, 12'h81E, "R6");
    wr(1'b1, 8, 1'b1, 12'h066, "R6");
    qry(8'h21, packH(5, 6, 7, 8), "R5");
    // R8 same entry on both ports of bank 0
    qry(8'h22, packH(5, 5, 7, 8), "R8");
    // R4 clear one presence bit, then re-query right after the write (R6)
    wr(1'b1, 8, 1'b0, 12'hFFF, "R6");
    qry(8'h23, packH(5, 6, 7, 8), "R4");
    qry(8'h24, packH(6, 5, 8, 7), "R4");
    wr(1'b1, 8, 1'b1, 12'h400, "R6");
    qry(8'h25, packH(6, 5, 8, 7), "R5");
    idle("R2"); idle("R2");

    // R9 / R3 random back-to-back traffic with bubbles
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 4) != 0)
        qry(8'($urandom), 40'({$urandom, $urandom}), "R3");
      else
        idle("R9");
    end
    idle("R9"); idle("R9"); idle("R9");
    finishRun();
  end
endmodule